// File: doc/BRIEF.md
# Increment-Only Counter Slot Controller

This block holds a segment that is split into several independent counters, each a fixed number of bytes wide (eight by default). A requester reads a counter by giving its slot index, or proposes a new value for it. A proposal is taken only when it is exactly one more than the value now in the slot. Any other proposal is refused and the slot keeps its value. Every counter therefore only ever steps upward by one, and the storage side enforces this. All slots share one configuration, the segment and counter sizes given by parameters. The slot count is the segment size divided by the counter size.

Requests arrive on a valid/ready channel. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low while reset is applied and high from the first edge after reset, so requests may be issued back to back with no gaps. The response channel has no back-pressure. Each taken request produces a single-cycle response on the following cycle: `rsp_valid` is high with exactly one of `rsp_ok` or `rsp_fail`, and `rsp_data` holds the result. A request that follows a successful write to the same slot sees the new value.

Top module: `ctr_slot_ctrl`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `req_ready` and `rsp_valid` are low. `req_ready` is high from then on, and every slot reads zero after reset.
- R2: A read of an in-range slot gives `rsp_ok` with `rsp_data` equal to the slot's current value, in the cycle after the request is taken.
- R3: A write whose data equals the slot's current value plus one gives `rsp_ok`. The slot then holds that data, and `rsp_data` echoes it.
- R4: A write with any other data gives `rsp_fail`, leaves the slot unchanged, and returns the slot's unchanged value on `rsp_data`.
- R5: A slot holding all ones refuses every write, because wrap-around to zero is not allowed. It keeps the all-ones value.
- R6: A slot index equal to or above the slot count gives `rsp_fail` with `rsp_data` zero, for both reads and writes. No slot changes.
- R7: `rsp_ok` and `rsp_fail` are never high together, are high only while `rsp_valid` is high, and each response lasts exactly one cycle.
- R8: A write to one slot leaves every other slot unchanged.
- R9: Every taken request gets its response exactly one cycle later, including back-to-back requests. A request directly after a successful write to the same slot sees the written value.
- R10: No response appears without a request taken in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = propose a new value, 0 = read |
| req_slot | input | IDX_W | Slot index |
| req_data | input | 8*CTR_BYTES | Proposed value (writes only) |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_ok | output | 1 | Request succeeded |
| rsp_fail | output | 1 | Request refused |
| rsp_data | output | 8*CTR_BYTES | Read value, accepted value, or unchanged value; zero for a bad index |

## Verification
The bench runs the block with one-byte counters, so that one slot can be stepped all the way to all ones. There it tries proposals of zero and of all ones. A design that lets the increment carry out would accept zero and wrap the counter. The bench also sends back-to-back proposals of consecutive values to one slot. A design that updated storage a cycle late would refuse the second proposal. Indices above the slot count, and proposals of stale or skipped values, are mixed in. These catch a design that aliases a bad index onto a real slot, or that keeps a refused value anyway.

// File: rtl/ctr_slot_pkg.sv
package ctr_slot_pkg;

  typedef enum logic [1:0] {
    VERDICT_NONE = 2'd0,
    VERDICT_OK   = 2'd1,
    VERDICT_FAIL = 2'd2
  } verdict_e;

endpackage

// File: rtl/ctr_slot_store.sv
module ctr_slot_store #(
  parameter int NUM_SLOTS = 4,
  parameter int CTR_W     = 64,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_value,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CTR_W-1:0] wr_value
);

  logic [CTR_W-1:0] slot_q [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        slot_q[g] <= wr_value;
      end
    end
  end

  always_comb begin
    rd_value = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_value = slot_q[i];
    end
  end

endmodule

// File: rtl/ctr_slot_judge.sv
module ctr_slot_judge
  import ctr_slot_pkg::*;
#(
  parameter int CTR_W = 64
) (
  input  logic             take,
  input  logic             is_write,
  input  logic             in_range,
  input  logic [CTR_W-1:0] current,
  input  logic [CTR_W-1:0] candidate,
  output verdict_e         verdict,
  output logic             commit,
  output logic [CTR_W-1:0] result
);

  logic             carry;
  logic [CTR_W-1:0] successor;

  assign {carry, successor} = {1'b0, current} + {{CTR_W{1'b0}}, 1'b1};

  always_comb begin
    verdict = VERDICT_NONE;
    commit  = 1'b0;
    result  = '0;
    if (take) begin
      if (!in_range) begin
        verdict = VERDICT_FAIL;
      end else if (!is_write) begin
        verdict = VERDICT_OK;
        result  = current;
      end else if (!carry && (candidate == successor)) begin
        verdict = VERDICT_OK;
        commit  = 1'b1;
        result  = candidate;
      end else begin
        verdict = VERDICT_FAIL;
        result  = current;
      end
    end
  end

endmodule

// File: rtl/ctr_slot_resp.sv
module ctr_slot_resp
  import ctr_slot_pkg::*;
#(
  parameter int CTR_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  verdict_e         verdict,
  input  logic [CTR_W-1:0] result,
  output logic             rsp_valid,
  output logic             rsp_ok,
  output logic             rsp_fail,
  output logic [CTR_W-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_fail  <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= (verdict != VERDICT_NONE);
      rsp_ok    <= (verdict == VERDICT_OK);
      rsp_fail  <= (verdict == VERDICT_FAIL);
      rsp_data  <= result;
    end
  end

endmodule

// File: rtl/ctr_slot_ctrl.sv
module ctr_slot_ctrl
  import ctr_slot_pkg::*;
#(
  parameter int SEG_BYTES = 32,
  parameter int CTR_BYTES = 8,
  parameter int IDX_W     = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [IDX_W-1:0]       req_slot,
  input  logic [8*CTR_BYTES-1:0] req_data,
  output logic                   rsp_valid,
  output logic                   rsp_ok,
  output logic                   rsp_fail,
  output logic [8*CTR_BYTES-1:0] rsp_data
);

  localparam int CTR_W     = 8 * CTR_BYTES;
  localparam int NUM_SLOTS = SEG_BYTES / CTR_BYTES;

  logic             ready_q;
  logic             take;
  logic             in_range;
  logic [CTR_W-1:0] current;
  logic             commit;
  logic [CTR_W-1:0] result;
  verdict_e         verdict;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign req_ready = ready_q;
  assign take      = req_valid && ready_q;
  assign in_range  = ({1'b0, req_slot} < (IDX_W+1)'(NUM_SLOTS));

  ctr_slot_store #(
    .NUM_SLOTS(NUM_SLOTS),
    .CTR_W    (CTR_W),
    .IDX_W    (IDX_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (req_slot),
    .rd_value(current),
    .wr_en   (commit),
    .wr_idx  (req_slot),
    .wr_value(req_data)
  );

  ctr_slot_judge #(
    .CTR_W(CTR_W)
  ) u_judge (
    .take     (take),
    .is_write (req_write),
    .in_range (in_range),
    .current  (current),
    .candidate(req_data),
    .verdict  (verdict),
    .commit   (commit),
    .result   (result)
  );

  ctr_slot_resp #(
    .CTR_W(CTR_W)
  ) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .verdict  (verdict),
    .result   (result),
    .rsp_valid(rsp_valid),
    .rsp_ok   (rsp_ok),
    .rsp_fail (rsp_fail),
    .rsp_data (rsp_data)
  );

endmodule

// File: rtl/ctr_slot_ctrl_chk.sv
module ctr_slot_ctrl_chk #(
  parameter int CTR_W     = 64,
  parameter int IDX_W     = 3,
  parameter int NUM_SLOTS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [IDX_W-1:0] req_slot,
  input logic [CTR_W-1:0] req_data,
  input logic             rsp_valid,
  input logic             rsp_ok,
  input logic             rsp_fail,
  input logic [CTR_W-1:0] rsp_data
);

  logic taken;
  logic bad_idx;
  assign taken   = req_valid && req_ready;
  assign bad_idx = (int'(req_slot) >= NUM_SLOTS);

  // R1
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> req_ready);

  // R7
  verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_ok, rsp_fail}) == 1));

  // R7
  verdict_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_ok && !rsp_fail));

  // R10
  rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(taken));

  // R9
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> rsp_valid);

  // R3
  wr_ok_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ok && $past(req_write)) |-> (rsp_data == $past(req_data)));

  // R4
  wr_fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fail && $past(req_write) && !$past(bad_idx))
      |-> ((CTR_W'(rsp_data + 1'b1) != $past(req_data)) || (&rsp_data)));

  // R6
  bad_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(bad_idx)) |-> (rsp_fail && (rsp_data == '0)));

endmodule

bind ctr_slot_ctrl ctr_slot_ctrl_chk #(
  .CTR_W    (CTR_W),
  .IDX_W    (IDX_W),
  .NUM_SLOTS(NUM_SLOTS)
) chk_i (.*);

// File: tb/ctr_slot_ctrl_test.sv
`timescale 1ns/1ps
module ctr_slot_ctrl_test;

  localparam int SEG   = 4;
  localparam int CB    = 1;
  localparam int W     = 8 * CB;
  localparam int SLOTS = SEG / CB;
  localparam int IW    = 3;
  localparam int MAXV  = (1 << W) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [IW-1:0] req_slot = '0;
  logic [W-1:0]  req_data = '0;
  logic          rsp_valid, rsp_ok, rsp_fail;
  logic [W-1:0]  rsp_data;

  always #2 clk = ~clk;

  ctr_slot_ctrl #(.SEG_BYTES(SEG), .CTR_BYTES(CB), .IDX_W(IW)) uut (.*);

  int    mem [SLOTS];
  bit    exp_ready, exp_valid, exp_ok, exp_fail;
  int    exp_data;
  string cur_tag = "R1";
  string exp_tag = "R1";
  int    compared = 0;
  int    mismatched = 0;
  bit    done = 0;

  // behavioural reference, evaluated at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mem[i]) mem[i] = 0;
      exp_ready = 0; exp_valid = 0; exp_ok = 0; exp_fail = 0; exp_data = 0;
      exp_tag = "R1";
    end else begin
      exp_valid = req_valid && exp_ready;
      exp_ok = 0; exp_fail = 0; exp_data = 0;
      exp_tag = cur_tag;
      if (exp_valid) begin
        int s;
        s = int'(req_slot);
        if (s >= SLOTS) begin
          exp_fail = 1;
        end else if (!req_write) begin
          exp_ok = 1; exp_data = mem[s];
        end else if (mem[s] != MAXV && int'(req_data) == mem[s] + 1) begin
          exp_ok = 1; exp_data = int'(req_data); mem[s] = int'(req_data);
        end else begin
          exp_fail = 1; exp_data = mem[s];
        end
      end
      exp_ready = 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (req_ready !== exp_ready || rsp_valid !== exp_valid || rsp_ok !== exp_ok ||
          rsp_fail !== exp_fail || (exp_valid && int'(rsp_data) != exp_data)) begin
        mismatched++;
        $display("FAIL %s: ready/valid/ok/fail/data = %0b/%0b/%0b/%0b/%0d, expected %0b/%0b/%0b/%0b/%0d",
                 exp_tag, req_ready, rsp_valid, rsp_ok, rsp_fail, rsp_data,
                 exp_ready, exp_valid, exp_ok, exp_fail, exp_data);
      end
    end
  end

  task automatic issue(input bit wr, input int slot, input int data, input string tag);
    cur_tag   = tag;
    req_valid = 1'b1;
    req_write = wr;
    req_slot  = IW'(slot);
    req_data  = W'(data);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    cur_tag = tag;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    bit [7:0] lfsr;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(2, "R1");
    // R1: all slots zero after reset
    for (int i = 0; i < SLOTS; i++) issue(0, i, 0, "R1");
    // R3 / R9: back-to-back increments on slot 0
    issue(1, 0, 1, "R3");
    issue(1, 0, 2, "R9");
    issue(1, 0, 3, "R9");
    issue(0, 0, 0, "R2");
    // R4: stale, skipped and equal proposals
    issue(1, 1, 5, "R4");
    issue(1, 1, 0, "R4");
    issue(1, 0, 3, "R4");
    issue(1, 0, 5, "R4");
    issue(0, 1, 0, "R4");
    issue(0, 0, 0, "R4");
    // R8: slot independence
    issue(1, 2, 1, "R8");
    for (int i = 0; i < SLOTS; i++) issue(0, i, 0, "R8");
    // R6: out-of-range indices
    for (int i = SLOTS; i < (1 << IW); i++) begin
      issue(0, i, 0, "R6");
      issue(1, i, 1, "R6");
    end
    for (int i = 0; i < SLOTS; i++) issue(0, i, 0, "R6");
    // R7 / R10: idle gaps produce no response
    idle(5, "R10");
    issue(0, 2, 0, "R7");
    idle(3, "R7");
    // R5: run slot 3 to all ones, then try to wrap
    for (int v = 1; v <= MAXV; v++) issue(1, 3, v, "R5");
    issue(1, 3, 0, "R5");
    issue(1, 3, MAXV, "R5");
    issue(0, 3, 0, "R5");
    // R9: mixed traffic with gaps
    lfsr = 8'h5A;
    for (int k = 0; k < 200; k++) begin
      int s, d;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      s = int'(lfsr[2:0]);
      d = (s < SLOTS && lfsr[4]) ? (mem[s] + 1) & MAXV : int'(lfsr);
      issue(lfsr[3], s, d, "R9");
      if (lfsr[6] && lfsr[7]) idle(1, "R10");
    end
    idle(3, "R7");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule